// File: doc/BRIEF.md
# Paged Packet Buffer Access Port

This block gives a host microprocessor programmed-I/O access to two byte-organised packet memories through one 16-bit data port. The first is an isochronous buffer built from two ping-pong halves. The second is a single asynchronous buffer. The processor writes a command code once to pick a buffer and a direction. It then streams any number of 16-bit reads or writes. Each accepted access moves two consecutive bytes and advances an internal byte pointer by two.

A programmed transfer length, counted in bytes, ends the stream. When the pointer reaches that length, the block raises an end-of-transfer interrupt flag and updates the full flag of the buffer it was working on. From then on it ignores the data port until the next command.

A start-of-frame pulse swaps the isochronous half that the processor sees. When both halves are marked full, the swap is held off and the processor is pinned to half 1.

Top module: `pbuf_access_port`

## Requirements
- R1: A command is decoded from `cmd_code` only when bits [6:1] equal 6'b100000. Bit 7 selects write (1) or read (0), and bit 0 selects the asynchronous (1) or isochronous (0) buffer, so the valid codes are 0x40, 0xC0, 0x41 and 0xC1. Any other code leaves no active transfer, and until the next valid command the block ignores data writes and returns 0x0000 on reads.
- R2: Each accepted data access transfers two bytes and advances the byte pointer by 2. A new command resets the pointer to 0, so the words of a write run read back in the same order in a later read run.
- R3: `dat_wdata[7:0]` and `dat_rdata[7:0]` map to the even byte address, and bits [15:8] map to the following odd byte.
- R4: `dat_rdata` is updated one clock after a `dat_rd` strobe and keeps its value until the next read strobe.
- R5: End-of-transfer occurs on the access that brings the pointer equal to `xfer_cnt`. An odd count is first rounded up to the next even value.
- R6: After end-of-transfer, data strobes have no effect and reads return 0x0000 until a new command.
- R7: End-of-transfer sets `irq_stat[2]` one clock later. A pulse on `irq_clr` clears it, and a set in the same cycle wins. All other `irq_stat` bits read 0.
- R8: `buf_full` bit 0 is isochronous half 0, bit 1 is half 1, and bit 2 is the asynchronous buffer. End-of-transfer on a write sets the targeted flag. End-of-transfer on a read clears it.
- R9: A `sof` pulse toggles the selected isochronous half unless both isochronous full flags are set.
- R10: While both isochronous full flags are set, `iso_sel` reads 1 and isochronous accesses go to half 1, whatever the selection held before.
- R11: A data strobe whose direction does not match the active command is ignored. A read in write mode returns 0x0000, and neither strobe moves the pointer.
- R12: After reset, no transfer is active, `buf_full`, `irq_stat` and `dat_rdata` are 0, and `iso_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle strobe that writes the command code |
| cmd_code | input | 8 | Command code: bit 7 direction, bit 0 buffer |
| dat_wr | input | 1 | One-cycle data-port write strobe |
| dat_rd | input | 1 | One-cycle data-port read strobe |
| dat_wdata | input | 16 | Write word: low byte even, high byte odd |
| dat_rdata | output | 16 | Read word, valid the cycle after `dat_rd` |
| xfer_cnt | input | MAX_AW+1 (10) | Transfer length in bytes |
| sof | input | 1 | One-cycle start-of-frame pulse |
| irq_clr | input | 1 | Clears the end-of-transfer interrupt flag |
| irq_stat | output | 8 | Interrupt status; bit 2 is end-of-transfer |
| buf_full | output | 3 | Full flags: {async, iso half 1, iso half 0} |
| iso_sel | output | 1 | Isochronous half the processor accesses |

## Verification
On every cycle, the assertions check how the pointer moves: it resets on a command, steps by two on an accepted access, and stays frozen once the transfer is done. They also check the interrupt flag's set and clear timing, and that start-of-frame either toggles or holds the half selection according to the two isochronous full flags. What the data memory holds only shows up through the bench's scenarios. These scenarios cover write-then-read round trips in both buffers and both halves, rounding of an odd count, pinning to half 1 while the stored selection is 0, and discarded strobes after an invalid command, after end-of-transfer, or with the wrong direction.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

  typedef enum logic { DIR_RD = 1'b0, DIR_WR = 1'b1 } dir_e;
  typedef enum logic { TGT_ISO = 1'b0, TGT_ASY = 1'b1 } tgt_e;

  typedef struct packed {
    logic ok;
    dir_e dir;
    tgt_e tgt;
  } cmd_t;

  // command bits [6:1] must match this stem; bit 7 = direction, bit 0 = buffer
  localparam logic [5:0] CMD_STEM    = 6'b100000;
  localparam int         IRQ_EOT_BIT = 2;
  localparam int         NBUF        = 3;

  function automatic cmd_t decode_cmd(input logic [7:0] code);
    cmd_t c;
    c.ok  = (code[6:1] == CMD_STEM);
    c.dir = dir_e'(code[7]);
    c.tgt = tgt_e'(code[0]);
    return c;
  endfunction

endpackage

// File: rtl/pbuf_byte_ram.sv
module pbuf_byte_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-2:0] waddr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] lo_a;
  logic [AW-1:0] hi_a;

  assign lo_a = {waddr, 1'b0};
  assign hi_a = {waddr, 1'b1};

  always_ff @(posedge clk) begin
    if (we) begin
      mem[lo_a] <= wdata[7:0];
      mem[hi_a] <= wdata[15:8];
    end
  end

  assign rdata = {mem[hi_a], mem[lo_a]};

endmodule

// File: rtl/pbuf_cmd_ctrl.sv
module pbuf_cmd_ctrl
  import pbuf_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic [PTR_W-1:0] xfer_cnt,
  output logic             acc,
  output logic             acc_wr,
  output logic             eot,
  output logic [PTR_W-1:0] ptr,
  output dir_e             cur_dir,
  output tgt_e             cur_tgt,
  output logic             done
);
  cmd_t             cmd;
  logic             act_q, act_d;
  logic             done_q, done_d;
  dir_e             dir_q, dir_d;
  tgt_e             tgt_q, tgt_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] cnt_even;
  logic [PTR_W-1:0] ptr_inc;
  logic             strobe_ok;

  assign cmd      = decode_cmd(cmd_code);
  assign cnt_even = xfer_cnt + {{(PTR_W-1){1'b0}}, xfer_cnt[0]};
  assign ptr_inc  = ptr_q + PTR_W'(2);

  always_comb begin
    strobe_ok = act_q && !done_q && !cmd_wr &&
                ((dat_wr && dir_q == DIR_WR) || (dat_rd && dir_q == DIR_RD));
    acc    = strobe_ok;
    acc_wr = strobe_ok && (dir_q == DIR_WR);
    eot    = strobe_ok && (ptr_inc == cnt_even);
  end

  always_comb begin
    act_d  = act_q;
    done_d = done_q;
    dir_d  = dir_q;
    tgt_d  = tgt_q;
    ptr_d  = ptr_q;
    if (cmd_wr) begin
      act_d  = cmd.ok;
      done_d = 1'b0;
      dir_d  = cmd.dir;
      tgt_d  = cmd.tgt;
      ptr_d  = '0;
    end else if (strobe_ok) begin
      ptr_d  = ptr_inc;
      done_d = eot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= DIR_RD;
      tgt_q  <= TGT_ISO;
      ptr_q  <= '0;
    end else begin
      act_q  <= act_d;
      done_q <= done_d;
      dir_q  <= dir_d;
      tgt_q  <= tgt_d;
      ptr_q  <= ptr_d;
    end
  end

  assign ptr     = ptr_q;
  assign cur_dir = dir_q;
  assign cur_tgt = tgt_q;
  assign done    = done_q;

endmodule

// File: rtl/pbuf_status.sv
module pbuf_status
  import pbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       eot,
  input  dir_e       eot_dir,
  input  tgt_e       eot_tgt,
  input  logic       irq_clr,
  output logic [2:0] buf_full,
  output logic       iso_sel,
  output logic       sel_q,
  output logic [7:0] irq_stat
);
  logic [2:0] full_q, full_d;
  logic       sel_r, sel_d;
  logic       irq_q, irq_d;
  logic       iso_both;

  assign iso_both = full_q[0] && full_q[1];
  assign iso_sel  = iso_both ? 1'b1 : sel_r;

  always_comb begin
    full_d = full_q;
    sel_d  = sel_r;
    irq_d  = irq_q;
    if (eot) begin
      if (eot_tgt == TGT_ASY) full_d[2]               = (eot_dir == DIR_WR);
      else if (iso_sel)       full_d[1]               = (eot_dir == DIR_WR);
      else                    full_d[0]               = (eot_dir == DIR_WR);
    end
    if (sof && !iso_both) sel_d = ~sel_r;
    if (eot)          irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      sel_r  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      sel_r  <= sel_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    irq_stat              = '0;
    irq_stat[IRQ_EOT_BIT] = irq_q;
  end

  assign buf_full = full_q;
  assign sel_q    = sel_r;

endmodule

// File: rtl/pbuf_access_port.sv
module pbuf_access_port
  import pbuf_pkg::*;
#(
  parameter  int ISO_AW = 8,
  parameter  int ASY_AW = 9,
  localparam int MAX_AW = (ISO_AW > ASY_AW) ? ISO_AW : ASY_AW,
  localparam int PTR_W  = MAX_AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic [15:0]      dat_wdata,
  output logic [15:0]      dat_rdata,
  input  logic [PTR_W-1:0] xfer_cnt,
  input  logic             sof,
  input  logic             irq_clr,
  output logic [7:0]       irq_stat,
  output logic [2:0]       buf_full,
  output logic             iso_sel
);
  logic             acc;
  logic             acc_wr;
  logic             eot;
  logic [PTR_W-1:0] ptr;
  logic             done;
  logic             sel_q;
  dir_e             cur_dir;
  tgt_e             cur_tgt;
  logic [1:0]       bank;
  logic [15:0]      rd_bank [NBUF];
  logic [15:0]      rd_mux;
  logic [15:0]      rdata_q, rdata_d;

  pbuf_cmd_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_code (cmd_code),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd),
    .xfer_cnt (xfer_cnt),
    .acc      (acc),
    .acc_wr   (acc_wr),
    .eot      (eot),
    .ptr      (ptr),
    .cur_dir  (cur_dir),
    .cur_tgt  (cur_tgt),
    .done     (done)
  );

  pbuf_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof      (sof),
    .eot      (eot),
    .eot_dir  (cur_dir),
    .eot_tgt  (cur_tgt),
    .irq_clr  (irq_clr),
    .buf_full (buf_full),
    .iso_sel  (iso_sel),
    .sel_q    (sel_q),
    .irq_stat (irq_stat)
  );

  // bank 0/1: isochronous halves, bank 2: asynchronous buffer
  assign bank = (cur_tgt == TGT_ASY) ? 2'd2 : {1'b0, iso_sel};

  for (genvar g = 0; g < NBUF; g++) begin : g_ram
    localparam int AWG = (g == 2) ? ASY_AW : ISO_AW;
    logic we_g;
    assign we_g = acc_wr && (bank == 2'(g));
    pbuf_byte_ram #(.AW(AWG)) u_ram (
      .clk   (clk),
      .we    (we_g),
      .waddr (ptr[AWG-1:1]),
      .wdata (dat_wdata),
      .rdata (rd_bank[g])
    );
  end

  always_comb begin
    case (bank)
      2'd0:    rd_mux = rd_bank[0];
      2'd1:    rd_mux = rd_bank[1];
      default: rd_mux = rd_bank[2];
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (dat_rd) rdata_d = (acc && !acc_wr) ? rd_mux : 16'h0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign dat_rdata = rdata_q;

endmodule

// File: rtl/pbuf_access_port_chk.sv
module pbuf_access_port_chk #(
  parameter int PTR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic             dat_wr,
  input logic             sof,
  input logic             irq_clr,
  input logic             acc,
  input logic             eot,
  input logic [PTR_W-1:0] ptr,
  input logic             done,
  input logic             sel_q,
  input logic [2:0]       buf_full,
  input logic [7:0]       irq_stat
);

  assert_cmd_rewinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (ptr == '0));

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cmd_wr) |=> (ptr == $past(ptr) + PTR_W'(2)));

  assert_done_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_wr) |=> $stable(ptr));

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> irq_stat[2]);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !eot) |=> !irq_stat[2]);

  assert_wr_eot_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eot && dat_wr) |=> (buf_full != 3'b000));

  assert_sof_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && buf_full[1:0] != 2'b11) |=> (sel_q != $past(sel_q)));

  assert_sof_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && buf_full[1:0] == 2'b11) |=> (sel_q == $past(sel_q)));

endmodule

bind pbuf_access_port pbuf_access_port_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_wr   (cmd_wr),
  .dat_wr   (dat_wr),
  .sof      (sof),
  .irq_clr  (irq_clr),
  .acc      (acc),
  .eot      (eot),
  .ptr      (ptr),
  .done     (done),
  .sel_q    (sel_q),
  .buf_full (buf_full),
  .irq_stat (irq_stat)
);

// File: tb/pbuf_access_port_bench.sv
`timescale 1ns/1ps
module pbuf_access_port_bench;

  localparam logic [3:0] OP_CNT = 4'd0;
  localparam logic [3:0] OP_CMD = 4'd1;
  localparam logic [3:0] OP_WR  = 4'd2;
  localparam logic [3:0] OP_RD  = 4'd3;
  localparam logic [3:0] OP_SOF = 4'd4;
  localparam logic [3:0] OP_FUL = 4'd5;
  localparam logic [3:0] OP_IRQ = 4'd6;
  localparam logic [3:0] OP_SEL = 4'd7;
  localparam int NV = 57;

  // {op, data, expected}
  localparam logic [35:0] VEC [NV] = '{
    {OP_CNT, 16'h0006, 16'h0000},  // 0
    {OP_CMD, 16'h00C1, 16'h0000},  // async write
    {OP_WR,  16'h1122, 16'h0000},
    {OP_WR,  16'h3344, 16'h0000},
    {OP_WR,  16'h5566, 16'h0000},  // R5 count 6 reached
    {OP_FUL, 16'h0000, 16'h0004},  // R8 async full
    {OP_IRQ, 16'h0000, 16'h0004},  // R7 bit 2
    {OP_WR,  16'h7788, 16'h0000},  // R6 ignored
    {OP_CMD, 16'h0041, 16'h0000},  // async read
    {OP_RD,  16'h0000, 16'h1122},  // R2 R3 R4
    {OP_RD,  16'h0000, 16'h3344},  // 10
    {OP_RD,  16'h0000, 16'h5566},
    {OP_RD,  16'h0000, 16'h0000},  // R6 after end
    {OP_FUL, 16'h0000, 16'h0000},  // R8 read clears
    {OP_CNT, 16'h0003, 16'h0000},  // R5 odd count -> 4
    {OP_CMD, 16'h00C0, 16'h0000},  // iso write, half 0
    {OP_WR,  16'hA0A1, 16'h0000},
    {OP_FUL, 16'h0000, 16'h0000},  // R5 not yet
    {OP_WR,  16'hA2A3, 16'h0000},
    {OP_FUL, 16'h0000, 16'h0001},  // R8 half 0
    {OP_SOF, 16'h0000, 16'h0000},  // 20
    {OP_SEL, 16'h0000, 16'h0001},  // R9
    {OP_CMD, 16'h00C0, 16'h0000},
    {OP_WR,  16'hB0B1, 16'h0000},
    {OP_WR,  16'hB2B3, 16'h0000},
    {OP_FUL, 16'h0000, 16'h0003},  // R8 half 1
    {OP_SOF, 16'h0000, 16'h0000},  // suppressed
    {OP_SEL, 16'h0000, 16'h0001},  // R10
    {OP_CMD, 16'h0040, 16'h0000},
    {OP_RD,  16'h0000, 16'hB0B1},
    {OP_RD,  16'h0000, 16'hB2B3},  // 30
    {OP_FUL, 16'h0000, 16'h0001},
    {OP_SOF, 16'h0000, 16'h0000},
    {OP_SEL, 16'h0000, 16'h0000},  // R9
    {OP_CMD, 16'h0040, 16'h0000},
    {OP_RD,  16'h0000, 16'hA0A1},
    {OP_RD,  16'h0000, 16'hA2A3},
    {OP_FUL, 16'h0000, 16'h0000},
    {OP_SOF, 16'h0000, 16'h0000},
    {OP_SEL, 16'h0000, 16'h0001},
    {OP_CMD, 16'h00C0, 16'h0000},  // 40 half 1 first
    {OP_WR,  16'hC0C1, 16'h0000},
    {OP_WR,  16'hC2C3, 16'h0000},
    {OP_FUL, 16'h0000, 16'h0002},
    {OP_SOF, 16'h0000, 16'h0000},
    {OP_SEL, 16'h0000, 16'h0000},
    {OP_CMD, 16'h00C0, 16'h0000},
    {OP_WR,  16'hD0D1, 16'h0000},
    {OP_WR,  16'hD2D3, 16'h0000},
    {OP_FUL, 16'h0000, 16'h0003},
    {OP_SEL, 16'h0000, 16'h0001},  // 50 R10 pinned, stored sel 0
    {OP_SOF, 16'h0000, 16'h0000},  // suppressed
    {OP_CMD, 16'h0040, 16'h0000},
    {OP_RD,  16'h0000, 16'hC0C1},  // R10 reads half 1
    {OP_RD,  16'h0000, 16'hC2C3},
    {OP_FUL, 16'h0000, 16'h0001},
    {OP_SEL, 16'h0000, 16'h0000}   // back to stored sel
  };

  logic        clk;
  logic        rst_n;
  logic        cmd_wr;
  logic [7:0]  cmd_code;
  logic        dat_wr;
  logic        dat_rd;
  logic [15:0] dat_wdata;
  logic [15:0] dat_rdata;
  logic [9:0]  xfer_cnt;
  logic        sof;
  logic        irq_clr;
  logic [7:0]  irq_stat;
  logic [2:0]  buf_full;
  logic        iso_sel;

  int n_chk;
  int n_fail;
  int cyc;
  bit finished;

  pbuf_access_port u_pbuf_access_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_code  (cmd_code),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd),
    .dat_wdata (dat_wdata),
    .dat_rdata (dat_rdata),
    .xfer_cnt  (xfer_cnt),
    .sof       (sof),
    .irq_clr   (irq_clr),
    .irq_stat  (irq_stat),
    .buf_full  (buf_full),
    .iso_sel   (iso_sel)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_cmd(input logic [7:0] c);
    cmd_wr = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic do_wr(input logic [15:0] d);
    dat_wr = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic do_rd(input string tag, input logic [15:0] exp);
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
    chk(tag, dat_rdata, exp);
  endtask

  task automatic pulse_sof();
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " buf_full"}, {13'd0, buf_full}, 16'h0000);
    chk({tag, " irq_stat"}, {8'd0, irq_stat}, 16'h0000);
    chk({tag, " iso_sel"}, {15'd0, iso_sel}, 16'h0000);
    chk({tag, " dat_rdata"}, dat_rdata, 16'h0000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; finished = 1'b0;
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_code = 8'h00;
    dat_wr = 1'b0; dat_rd = 1'b0; dat_wdata = 16'h0000;
    xfer_cnt = 10'd0; sof = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R12 reset");
    do_rd("R1 read before any command", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [15:0] dv;
      logic [15:0] ev;
      op = VEC[i][35:32];
      dv = VEC[i][31:16];
      ev = VEC[i][15:0];
      case (op)
        OP_CNT: begin xfer_cnt = dv[9:0]; @(negedge clk); end
        OP_CMD: do_cmd(dv[7:0]);
        OP_WR:  do_wr(dv);
        OP_RD:  do_rd($sformatf("R2 R3 R4 R6 row %0d", i), ev);
        OP_SOF: pulse_sof();
        OP_FUL: chk($sformatf("R8 buf_full row %0d", i), {13'd0, buf_full}, ev);
        OP_IRQ: chk($sformatf("R7 irq_stat row %0d", i), {8'd0, irq_stat}, ev);
        OP_SEL: chk($sformatf("R9 R10 iso_sel row %0d", i), {15'd0, iso_sel}, ev);
        default: ;
      endcase
    end

    // R7: clear by pulse
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R7 irq cleared", {8'd0, irq_stat}, 16'h0000);

    // R1: invalid code discards strobes
    xfer_cnt = 10'd4;
    do_cmd(8'h55);
    do_rd("R1 read under invalid code", 16'h0000);
    do_wr(16'hEEEE);
    do_cmd(8'h41);
    do_rd("R1 write under invalid code ignored", 16'h1122);
    chk("R5 no end before count", {8'd0, irq_stat}, 16'h0000);
    do_rd("R2 second async word", 16'h3344);
    chk("R5 end at count 4", {8'd0, irq_stat}, 16'h0004);

    // R11: wrong-direction strobe ignored
    do_cmd(8'hC1);
    do_rd("R11 read in write mode", 16'h0000);
    do_wr(16'h9999);
    do_wr(16'h8888);
    chk("R8 async full again", {13'd0, buf_full}, 16'h0005);
    do_cmd(8'h41);
    do_rd("R11 first word kept", 16'h9999);
    do_rd("R11 pointer not moved by read", 16'h8888);
    chk("R8 async cleared", {13'd0, buf_full}, 16'h0001);

    // R12: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R12 second reset");

    finish_run();
  end

endmodule